// File: doc/BRIEF.md
# Prefetchable Memory Window Decoder

This block sits in a bridge port and decides whether a processor memory request falls inside the port's prefetchable memory window. If it does, the request is routed downstream. Configuration software programs a window base and a window limit at 1 MB granularity. The 32-bit parts of these values go through two 16-bit configuration registers. The 64-bit variant adds two 32-bit upper registers that supply address bits 63:32 of the base and of the limit. Each of these upper registers is accessed as two 16-bit halves.

The configuration interface is a single-cycle, 16-bit path with byte enables. A write happens on the clock edge while `cfg_we` is high. Read data is combinational from `cfg_off`. A 64-bit request address goes in, and the hit flag comes out in the same cycle. The decode treats the 20 low bits of the limit as all ones, so the last byte of the limit's megabyte is inside the window. A window whose base is above its limit matches nothing.

The `CAP_WIDE` parameter chooses the variant. When it is 1, the port is 64-bit capable. When it is 0, the port decodes only 32-bit addresses. The read-only capability nibble reports which variant is built.

Top module: `pfwin_decoder`

## Requirements
- R1: After synchronous reset, both window fields and both upper registers are zero. With `CAP_WIDE=1`, reads at offsets 24h and 26h return 0001h.
- R2: Bits 15:4 of the base register (offset 24h) and of the limit register (offset 26h) are read/write. They hold request address bits 31:20 of the window's first and last megabyte.
- R3: Bits 3:0 of both registers are read-only. They always read the capability code, and writes to them have no effect.
- R4: The capability code is 1h when `CAP_WIDE=1` and 0h when `CAP_WIDE=0`. In the 32-bit variant, the upper registers read 0 and ignore writes, and any request with nonzero address bits 63:32 misses.
- R5: In the 64-bit variant, the upper base register is at 28h (bits 15:0) and 2Ah (bits 31:16). The upper limit register is at 2Ch (bits 15:0) and 2Eh (bits 31:16). All bits of these registers are read/write.
- R6: A request hits when {upper base, base field} ≤ address[63:20] ≤ {upper limit, limit field}. The compare is unsigned, and address bits 19:0 of the limit are taken as FFFFFh.
- R7: When {upper base, base} is greater than {upper limit, limit}, no request hits.
- R8: `cfg_be[0]` enables a write to bits 7:0 and `cfg_be[1]` enables a write to bits 15:8. Bytes whose enable is low keep their value.
- R9: Any offset other than 24h, 26h, 28h, 2Ah, 2Ch or 2Eh reads 0000h, and a write to it changes no register.
- R10: The hit output follows a new request address in the same cycle. A register write affects the hit from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_off | input | 8 | Configuration register offset |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for `cfg_off` (combinational) |
| req_addr | input | 64 | Processor request address |
| req_hit | output | 1 | Request falls inside the prefetchable window |

## Verification
The hardest cases to reach are at the window edges once the upper 32 bits take part. One such case is a limit field of 001h paired with a base field of FFEh, where only the carry across bit 32 makes the window non-empty. This is reachable only after several half-register writes have set both upper registers. The bench programs the upper base and upper limit over a small grid of values, and the window fields over values on either side of the 4 GB wrap. It then sweeps request addresses across that wrap and compares each result against arithmetic on the 44-bit keys. A second sweep covers every base/limit pair in a small low range, including inverted ones, against every nearby megabyte at its first and last byte.

// File: rtl/pfwin_pkg.sv
package pfwin_pkg;

    localparam int CFG_W      = 16;
    localparam int CFG_OFF_W  = 8;
    localparam int BE_W       = CFG_W / 8;
    localparam int CAP_W      = 4;
    localparam int ADDR_W     = 64;
    localparam int LOW_W      = 32;
    localparam int GRAN_SHIFT = 20;
    localparam int FIELD_W    = LOW_W - GRAN_SHIFT;
    localparam int UPPER_W    = ADDR_W - LOW_W;
    localparam int KEY_W      = UPPER_W + FIELD_W;

    localparam logic [CFG_OFF_W-1:0] OFF_BASE     = 8'h24;
    localparam logic [CFG_OFF_W-1:0] OFF_LIMIT    = 8'h26;
    localparam logic [CFG_OFF_W-1:0] OFF_UBASE_LO = 8'h28;
    localparam logic [CFG_OFF_W-1:0] OFF_UBASE_HI = 8'h2A;
    localparam logic [CFG_OFF_W-1:0] OFF_ULIM_LO  = 8'h2C;
    localparam logic [CFG_OFF_W-1:0] OFF_ULIM_HI  = 8'h2E;

    localparam logic [CAP_W-1:0] CAP_ADDR32 = 4'h0;
    localparam logic [CAP_W-1:0] CAP_ADDR64 = 4'h1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BASE,
        SEL_LIMIT,
        SEL_UBASE_LO,
        SEL_UBASE_HI,
        SEL_ULIM_LO,
        SEL_ULIM_HI
    } reg_sel_e;

    typedef struct packed {
        logic [UPPER_W-1:0] ubase;
        logic [FIELD_W-1:0] base;
        logic [UPPER_W-1:0] ulim;
        logic [FIELD_W-1:0] lim;
    } win_cfg_t;

    function automatic reg_sel_e decode_off(input logic [CFG_OFF_W-1:0] off);
        case (off)
            OFF_BASE:     return SEL_BASE;
            OFF_LIMIT:    return SEL_LIMIT;
            OFF_UBASE_LO: return SEL_UBASE_LO;
            OFF_UBASE_HI: return SEL_UBASE_HI;
            OFF_ULIM_LO:  return SEL_ULIM_LO;
            OFF_ULIM_HI:  return SEL_ULIM_HI;
            default:      return SEL_NONE;
        endcase
    endfunction

    function automatic logic [CFG_W-1:0] lane_merge(
        input logic [CFG_W-1:0] old_v,
        input logic [CFG_W-1:0] new_v,
        input logic [BE_W-1:0]  be
    );
        logic [CFG_W-1:0] r;
        r = old_v;
        for (int i = 0; i < BE_W; i++) begin
            if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pfwin_cfg_regs.sv
module pfwin_cfg_regs
    import pfwin_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_OFF_W-1:0] cfg_off,
    input  logic [BE_W-1:0]      cfg_be,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    output win_cfg_t             win
);
    localparam logic [CAP_W-1:0] CAP = WIDE ? CAP_ADDR64 : CAP_ADDR32;
    localparam int HALF = CFG_W;

    reg_sel_e            sel;
    logic [FIELD_W-1:0]  base_q, lim_q;
    logic [UPPER_W-1:0]  ubase_q, ulim_q;
    logic [CFG_W-1:0]    base_nx, lim_nx;
    logic                unused_ro_bits;

    assign sel = decode_off(cfg_off);

    // Merge with the current register image; the read-only nibble is dropped.
    always_comb begin
        base_nx = lane_merge({base_q, CAP}, cfg_wdata, cfg_be);
        lim_nx  = lane_merge({lim_q,  CAP}, cfg_wdata, cfg_be);
    end
    assign unused_ro_bits = ^{base_nx[CAP_W-1:0], lim_nx[CAP_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            lim_q  <= '0;
        end else if (cfg_we) begin
            if (sel == SEL_BASE)  base_q <= base_nx[CFG_W-1:CAP_W];
            if (sel == SEL_LIMIT) lim_q  <= lim_nx[CFG_W-1:CAP_W];
        end
    end

    generate
        if (WIDE) begin : g_wide
            always_ff @(posedge clk) begin
                if (rst) begin
                    ubase_q <= '0;
                    ulim_q  <= '0;
                end else if (cfg_we) begin
                    case (sel)
                        SEL_UBASE_LO: ubase_q[0 +: HALF]    <= lane_merge(ubase_q[0 +: HALF],    cfg_wdata, cfg_be);
                        SEL_UBASE_HI: ubase_q[HALF +: HALF] <= lane_merge(ubase_q[HALF +: HALF], cfg_wdata, cfg_be);
                        SEL_ULIM_LO:  ulim_q[0 +: HALF]     <= lane_merge(ulim_q[0 +: HALF],     cfg_wdata, cfg_be);
                        SEL_ULIM_HI:  ulim_q[HALF +: HALF]  <= lane_merge(ulim_q[HALF +: HALF],  cfg_wdata, cfg_be);
                        default: ;
                    endcase
                end
            end
        end else begin : g_narrow
            assign ubase_q = '0;
            assign ulim_q  = '0;
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_BASE:     cfg_rdata = {base_q, CAP};
            SEL_LIMIT:    cfg_rdata = {lim_q, CAP};
            SEL_UBASE_LO: cfg_rdata = ubase_q[0 +: HALF];
            SEL_UBASE_HI: cfg_rdata = ubase_q[HALF +: HALF];
            SEL_ULIM_LO:  cfg_rdata = ulim_q[0 +: HALF];
            SEL_ULIM_HI:  cfg_rdata = ulim_q[HALF +: HALF];
            default:      cfg_rdata = '0;
        endcase
    end

    assign win = '{ubase: ubase_q, base: base_q, ulim: ulim_q, lim: lim_q};

endmodule

// File: rtl/pfwin_cmp.sv
module pfwin_cmp
    import pfwin_pkg::*;
(
    input  win_cfg_t         win,
    input  logic [KEY_W-1:0] req_key,
    output logic [KEY_W-1:0] base_key,
    output logic [KEY_W-1:0] limit_key,
    output logic             hit
);
    assign base_key  = {win.ubase, win.base};
    assign limit_key = {win.ulim,  win.lim};

    // Comparing megabyte indices is the same as treating the limit's low 20 bits as all ones.
    assign hit = (req_key >= base_key) && (req_key <= limit_key);
endmodule

// File: rtl/pfwin_decoder.sv
module pfwin_decoder
    import pfwin_pkg::*;
#(
    parameter bit CAP_WIDE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_OFF_W-1:0] cfg_off,
    input  logic [BE_W-1:0]      cfg_be,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 req_hit
);
    win_cfg_t          win_q;
    logic [KEY_W-1:0]  base_key, limit_key;
    logic              unused_low_addr;

    assign unused_low_addr = ^req_addr[GRAN_SHIFT-1:0];

    pfwin_cfg_regs #(.WIDE(CAP_WIDE)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_off   (cfg_off),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win       (win_q)
    );

    pfwin_cmp u_cmp (
        .win       (win_q),
        .req_key   (req_addr[ADDR_W-1:GRAN_SHIFT]),
        .base_key  (base_key),
        .limit_key (limit_key),
        .hit       (req_hit)
    );
endmodule

// File: rtl/pfwin_checker.sv
module pfwin_checker
    import pfwin_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_we,
    input logic [CFG_OFF_W-1:0] cfg_off,
    input logic [BE_W-1:0]      cfg_be,
    input logic [CFG_W-1:0]     cfg_rdata,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 req_hit,
    input win_cfg_t             win,
    input logic [KEY_W-1:0]     base_key,
    input logic [KEY_W-1:0]     limit_key
);
    localparam logic [CAP_W-1:0] CAP = WIDE ? CAP_ADDR64 : CAP_ADDR32;

    assert_base_read_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_off == OFF_BASE) |-> (cfg_rdata == {win.base, CAP}));

    assert_limit_read_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_off == OFF_LIMIT) |-> (cfg_rdata == {win.lim, CAP}));

    assert_no_lane_no_change_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_be == '0) |=> $stable(win));

    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && decode_off(cfg_off) == SEL_NONE) |=> $stable(win));

    assert_inverted_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (base_key > limit_key) |-> !req_hit);

    assert_hit_steady_R10: assert property (@(posedge clk) disable iff (rst)
        ($stable(req_addr) && $stable(win)) |-> $stable(req_hit));

    generate
        if (!WIDE) begin : g_narrow_chk
            assert_narrow_upper_miss_R4: assert property (@(posedge clk) disable iff (rst)
                req_hit |-> (req_addr[ADDR_W-1:LOW_W] == '0));
        end
    endgenerate
endmodule

bind pfwin_decoder pfwin_checker #(.WIDE(CAP_WIDE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_off   (cfg_off),
    .cfg_be    (cfg_be),
    .cfg_rdata (cfg_rdata),
    .req_addr  (req_addr),
    .req_hit   (req_hit),
    .win       (win_q),
    .base_key  (base_key),
    .limit_key (limit_key)
);

// File: tb/tb_pfwin_decoder.sv
module tb_pfwin_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_off = 8'h00;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = 16'h0;
    logic [63:0] req_addr = 64'h0;
    logic [15:0] rd64, rd32;
    logic        hit64, hit32;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pfwin_decoder #(.CAP_WIDE(1'b1)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_off(cfg_off), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd64), .req_addr(req_addr), .req_hit(hit64));

    pfwin_decoder #(.CAP_WIDE(1'b0)) dut32 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_off(cfg_off), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd32), .req_addr(req_addr), .req_hit(hit32));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] off, input logic [15:0] data, input logic [1:0] be);
        @(negedge clk);
        cfg_we = 1'b1; cfg_off = off; cfg_wdata = data; cfg_be = be;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = 2'b00;
    endtask

    task automatic rd64_chk(input logic [7:0] off, input logic [15:0] exp, input string req);
        cfg_off = off; #1;
        check(rd64 == exp, req, 64'(rd64), 64'(exp));
    endtask

    task automatic rd32_chk(input logic [7:0] off, input logic [15:0] exp, input string req);
        cfg_off = off; #1;
        check(rd32 == exp, req, 64'(rd32), 64'(exp));
    endtask

    task automatic hit_chk(input logic [63:0] a, input bit e64, input bit e32, input string req);
        req_addr = a; #1;
        check(hit64 == e64, req, 64'(hit64), 64'(e64));
        check(hit32 == e32, req, 64'(hit32), 64'(e32));
    endtask

    task automatic set_window(input logic [31:0] ub, input logic [11:0] b,
                              input logic [31:0] ul, input logic [11:0] l);
        wr(8'h24, {b, 4'h0}, 2'b11);
        wr(8'h26, {l, 4'h0}, 2'b11);
        wr(8'h28, ub[15:0], 2'b11);
        wr(8'h2A, ub[31:16], 2'b11);
        wr(8'h2C, ul[15:0], 2'b11);
        wr(8'h2E, ul[31:16], 2'b11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish (all R tags)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values, R4 capability code in each variant
        rd64_chk(8'h24, 16'h0001, "R1 base reset");
        rd64_chk(8'h26, 16'h0001, "R1 limit reset");
        rd64_chk(8'h28, 16'h0000, "R1 upper base lo reset");
        rd64_chk(8'h2E, 16'h0000, "R1 upper limit hi reset");
        rd32_chk(8'h24, 16'h0000, "R4 narrow cap code");
        // reset window: base 0, limit 0 -> first megabyte only
        hit_chk(64'h0000_0000_000F_FFFF, 1'b1, 1'b1, "R1 reset window last byte");
        hit_chk(64'h0000_0000_0010_0000, 1'b0, 1'b0, "R1 reset window next MB");

        // R2/R3: full write, read-only nibble keeps capability
        wr(8'h24, 16'hFFFF, 2'b11);
        rd64_chk(8'h24, 16'hFFF1, "R3 base RO nibble");
        rd32_chk(8'h24, 16'hFFF0, "R3 narrow RO nibble");
        wr(8'h26, 16'hABCE, 2'b11);
        rd64_chk(8'h26, 16'hABC1, "R2 limit field");
        wr(8'h24, 16'h0000, 2'b11);
        wr(8'h26, 16'h0000, 2'b11);

        // R8 byte lanes
        wr(8'h24, 16'hABCD, 2'b01);
        rd64_chk(8'h24, 16'h00C1, "R8 low lane only");
        wr(8'h24, 16'h12FF, 2'b10);
        rd64_chk(8'h24, 16'h12C1, "R8 high lane only");
        wr(8'h24, 16'h5555, 2'b00);
        rd64_chk(8'h24, 16'h12C1, "R8 no lane");

        // R9 unmapped offsets
        wr(8'h30, 16'hFFFF, 2'b11);
        wr(8'h25, 16'hFFFF, 2'b11);
        rd64_chk(8'h30, 16'h0000, "R9 unmapped read");
        rd64_chk(8'h24, 16'h12C1, "R9 base untouched");
        rd64_chk(8'h26, 16'h0001, "R9 limit untouched");
        rd64_chk(8'h28, 16'h0000, "R9 upper untouched");

        // R5 upper registers, R4 narrow ignores them
        wr(8'h28, 16'h1234, 2'b11);
        wr(8'h2A, 16'h5678, 2'b11);
        wr(8'h2C, 16'h9ABC, 2'b11);
        wr(8'h2E, 16'hDEF0, 2'b11);
        rd64_chk(8'h28, 16'h1234, "R5 upper base lo");
        rd64_chk(8'h2A, 16'h5678, "R5 upper base hi");
        rd64_chk(8'h2C, 16'h9ABC, "R5 upper limit lo");
        rd64_chk(8'h2E, 16'hDEF0, "R5 upper limit hi");
        rd32_chk(8'h28, 16'h0000, "R4 narrow upper base");
        rd32_chk(8'h2E, 16'h0000, "R4 narrow upper limit");
        wr(8'h2C, 16'hFF00, 2'b01);
        rd64_chk(8'h2C, 16'h9A00, "R8 upper low lane");

        // R6/R7 sweep in the low 4 GB: every small base/limit pair
        for (int b = 0; b < 8; b++) begin
            for (int l = 0; l < 8; l++) begin
                set_window(32'h0, 12'(b), 32'h0, 12'(l));
                for (int m = 0; m < 10; m++) begin
                    bit e;
                    e = (b <= m) && (m <= l);
                    hit_chk({32'h0, 12'(m), 20'h00000}, e, e, (b > l) ? "R7 inverted window" : "R6 first byte");
                    hit_chk({32'h0, 12'(m), 20'hFFFFF}, e, e, (b > l) ? "R7 inverted window" : "R6 last byte");
                end
            end
        end

        // R6 sweep across the 4 GB wrap with upper registers in play
        for (int ub = 0; ub < 3; ub++) begin
            for (int ul = 0; ul < 3; ul++) begin
                set_window(32'(ub), 12'hFFE, 32'(ul), 12'h001);
                for (int ua = 0; ua < 4; ua++) begin
                    for (int fi = 0; fi < 6; fi++) begin
                        logic [11:0] f;
                        longint key, bk, lk;
                        bit e64, e32;
                        f = 12'(32'hFFD + fi);
                        key = (longint'(ua + ((fi >= 3) ? 1 : 0)) << 12) | longint'(f);
                        bk = (longint'(ub) << 12) | 64'hFFE;
                        lk = (longint'(ul) << 12) | 64'h001;
                        e64 = (key >= bk) && (key <= lk);
                        // narrow: base FFE, limit 001 with zero uppers -> empty
                        e32 = 1'b0;
                        hit_chk({32'(key >> 12), f, 20'h80000}, e64, e32, "R6 wide compare");
                    end
                end
            end
        end

        // R4 narrow: wide window covers upper=1, narrow must miss it
        set_window(32'h0, 12'h000, 32'h5, 12'hFFF);
        hit_chk(64'h0000_0000_4000_0000, 1'b1, 1'b1, "R4 low address both hit");
        hit_chk(64'h0000_0001_0000_0000, 1'b1, 1'b0, "R4 narrow upper miss");

        // R10: hit changes at the edge that stores the write, same cycle for address
        set_window(32'h0, 12'h005, 32'h0, 12'h004);
        hit_chk(64'h0000_0000_0050_0000, 1'b0, 1'b0, "R10 before write");
        @(negedge clk);
        cfg_we = 1'b1; cfg_off = 8'h26; cfg_wdata = 16'h0050; cfg_be = 2'b11;
        #1;
        check(hit64 == 1'b0, "R10 not before edge", 64'(hit64), 64'h0);
        @(posedge clk); #1;
        check(hit64 == 1'b1, "R10 after edge", 64'(hit64), 64'h1);
        cfg_we = 1'b0;
        req_addr = 64'h0000_0000_0060_0000; #1;
        check(hit64 == 1'b0, "R10 address same cycle", 64'(hit64), 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule